// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital controller in front of a multi-channel analog-to-digital converter core. Software loads a control word holding an operation mode, a channel number, a last-channel number, a timer-trigger enable and a start bit. An operation then begins from the software write or from a one-cycle timer-underflow pulse. The controller hands the core one channel at a time through a channel-select output and a one-cycle start strobe, waits for the core's done pulse, and stores each result in a result register indexed by channel number.

Two operations exist. Mode 00 converts one programmed channel once. Mode 01 scans from channel 0 upward to the programmed last channel, converting each once. During a scan the channel field is the live channel counter, and it returns to 0 when the scan ends. A busy flag is high for the whole operation. A single interrupt pulse marks its end, in the same cycle that busy drops.

The sequencer has three states. S_IDLE is the state after reset and the only state with busy low. S_LAUNCH drives the start strobe for one cycle. S_WAIT holds the channel select until the core reports done. The transitions are these. The accepted-start transition goes from S_IDLE to S_LAUNCH. The issue transition goes from S_LAUNCH to S_WAIT with no condition. The advance transition goes from S_WAIT to S_LAUNCH on done when a scan has channels left, and it increments the channel. The finish transition goes from S_WAIT to S_IDLE on done for the final conversion, and it raises the interrupt.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, irq and conv_start are 0, the channel field cur_chan is 0, and every result register reads 0.
- R2: In mode 2'b00 exactly one conversion is issued, and its conv_chan equals the programmed channel field. The last-channel field has no effect.
- R3: In mode 2'b01 conversions are issued for channels 0, 1, ... up to the last-channel field, in ascending order, one strobe per channel. The written channel field is not used as the start point.
- R4: During a scan, cur_chan equals the channel being converted, and it reads 0 after the scan. In mode 2'b00, cur_chan keeps the programmed value.
- R5: A write with cfg_start=1 and cfg_trig_en=0 starts the operation. A write with cfg_start=1 and cfg_trig_en=1 does not start anything.
- R6: A tmr_uf pulse starts the operation when the stored trigger enable is 1. When the stored trigger enable is 0, the pulse is ignored.
- R7: busy is 1 from the cycle after the start is accepted until the operation ends, and the hardware clears it to 0 when the operation ends.
- R8: irq is a one-cycle pulse. It occurs exactly once per operation, in the first cycle in which busy reads 0 again.
- R9: Each conv_data word returned with conv_done is stored at the index of the channel converted, and rd_data shows the register selected by rd_chan in the same cycle.
- R10: While busy is 1, control writes are ignored in all fields, and tmr_uf pulses are ignored.
- R11: In mode 2'b01 with the last-channel field at 0, only channel 0 is converted, followed by one irq.
- R12: conv_start is never high for two consecutive cycles. conv_chan stays stable from the strobe until conv_done.
- R13: Modes 2'b10 and 2'b11 start nothing: busy stays 0 and no strobe is issued. The fields are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_mode | input | 2 | Mode: 00 single channel, 01 scan |
| cfg_chan | input | CH_W | Channel to convert in mode 00 |
| cfg_last | input | CH_W | Final channel of a scan |
| cfg_trig_en | input | 1 | Timer-trigger enable |
| cfg_start | input | 1 | Software start bit |
| tmr_uf | input | 1 | Timer underflow pulse |
| busy | output | 1 | Operation in progress |
| cur_chan | output | CH_W | Channel field (live counter during a scan) |
| conv_start | output | 1 | One-cycle start strobe to the core |
| conv_chan | output | CH_W | Channel select to the core |
| conv_done | input | 1 | Core conversion complete |
| conv_data | input | RES_W | Core result word |
| irq | output | 1 | End-of-operation interrupt pulse |
| rd_chan | input | CH_W | Result register select |
| rd_data | output | RES_W | Selected result register |

## Verification
The bench aims at the boundaries of a scan: a last channel of 0 and of 15, and a written channel field that is not 0. A design that seeds the scan from the written field, or that stops one channel early or late, shows a wrong strobe sequence or a wrong conversion count. Start sources are crossed with the trigger enable, and writes and timer pulses are sent in the middle of a scan. A controller that lets these through would restart, change mode, or lose its timer trigger, and the follow-up timer-started scan exposes that. The reserved modes, the irq pulse lining up with busy falling, and the channel field reading 0 after a scan are each checked, so an extra or early interrupt, or a stale counter, is caught.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_WAIT   = 2'd2
    } seq_state_e;

    localparam logic [1:0] MODE_ONE  = 2'b00;
    localparam logic [1:0] MODE_SCAN = 2'b01;

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_mode,
    input  logic [CH_W-1:0] cfg_last,
    input  logic            cfg_trig_en,
    input  logic            cfg_start,
    input  logic            tmr_uf,
    output logic [1:0]      mode_q,
    output logic [CH_W-1:0] last_q,
    output logic            load_chan,
    output logic            go,
    output logic [1:0]      go_mode
);

    logic trig_q;
    logic sw_go;
    logic tmr_go;
    logic mode_ok;

    // writes only land while idle
    assign load_chan = cfg_we && !busy;
    assign go_mode   = load_chan ? cfg_mode : mode_q;
    assign mode_ok   = (go_mode == MODE_ONE) || (go_mode == MODE_SCAN);
    assign sw_go     = load_chan && cfg_start && !cfg_trig_en;
    assign tmr_go    = !busy && tmr_uf && trig_q;
    assign go        = (sw_go || tmr_go) && mode_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_ONE;
            last_q <= '0;
            trig_q <= 1'b0;
        end else if (load_chan) begin
            mode_q <= cfg_mode;
            last_q <= cfg_last;
            trig_q <= cfg_trig_en;
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [1:0]      go_mode,
    input  logic [1:0]      mode_q,
    input  logic [CH_W-1:0] last_q,
    input  logic            load_chan,
    input  logic [CH_W-1:0] cfg_chan,
    input  logic            conv_done,
    output logic            busy,
    output logic [CH_W-1:0] chan_q,
    output logic            conv_start,
    output logic            res_we,
    output logic            irq
);

    localparam logic [CH_W-1:0] CH_STEP = CH_W'(1);

    seq_state_e state_q, state_d;
    logic       is_final;

    assign is_final = (mode_q == MODE_ONE) || (chan_q == last_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (go) state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_WAIT;
            S_WAIT: begin
                if (conv_done) state_d = is_final ? S_IDLE : S_LAUNCH;
            end
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        conv_start = 1'b0;
        res_we     = 1'b0;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_LAUNCH: conv_start = 1'b1;
            S_WAIT:   res_we = conv_done;
            default:  busy = 1'b0;
        endcase
    end

    // channel field: programmed value or live scan counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (state_q == S_IDLE) begin
            if (go && go_mode == MODE_SCAN) chan_q <= '0;
            else if (load_chan)             chan_q <= cfg_chan;
        end else if (state_q == S_WAIT && conv_done) begin
            if (!is_final)                  chan_q <= chan_q + CH_STEP;
            else if (mode_q == MODE_SCAN)   chan_q <= '0;
        end
    end

    // end-of-operation pulse, aligned with busy falling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state_q == S_WAIT) && conv_done && is_final;
    end

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
    parameter int CH_W  = 4,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CH_W-1:0]  wr_idx,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_idx,
    output logic [RES_W-1:0] rd_data
);

    localparam int NUM_CH = 1 << CH_W;

    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0][RES_W-1:0] bank;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        assign hit[g] = we && (wr_idx == CH_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (hit[i]) bank[i] <= wr_data;
            end
        end
    end

    assign rd_data = bank[rd_idx];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic [CH_W-1:0]  cfg_last,
    input  logic             cfg_trig_en,
    input  logic             cfg_start,
    input  logic             tmr_uf,
    output logic             busy,
    output logic [CH_W-1:0]  cur_chan,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             irq,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data
);

    logic [1:0]      mode_q;
    logic [CH_W-1:0] last_q;
    logic            load_chan;
    logic            go;
    logic [1:0]      go_mode;
    logic [CH_W-1:0] chan_q;
    logic            res_we;

    adc_seq_cfg #(.CH_W(CH_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .cfg_we     (cfg_we),
        .cfg_mode   (cfg_mode),
        .cfg_last   (cfg_last),
        .cfg_trig_en(cfg_trig_en),
        .cfg_start  (cfg_start),
        .tmr_uf     (tmr_uf),
        .mode_q     (mode_q),
        .last_q     (last_q),
        .load_chan  (load_chan),
        .go         (go),
        .go_mode    (go_mode)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_mode   (go_mode),
        .mode_q    (mode_q),
        .last_q    (last_q),
        .load_chan (load_chan),
        .cfg_chan  (cfg_chan),
        .conv_done (conv_done),
        .busy      (busy),
        .chan_q    (chan_q),
        .conv_start(conv_start),
        .res_we    (res_we),
        .irq       (irq)
    );

    adc_seq_results #(.CH_W(CH_W), .RES_W(RES_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (res_we),
        .wr_idx (chan_q),
        .wr_data(conv_data),
        .rd_idx (rd_chan),
        .rd_data(rd_data)
    );

    assign cur_chan  = chan_q;
    assign conv_chan = chan_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            irq,
    input logic            conv_start,
    input logic            conv_done,
    input logic [CH_W-1:0] conv_chan,
    input logic [CH_W-1:0] cur_chan,
    input logic [1:0]      mode_q,
    input logic [CH_W-1:0] last_q
);

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    irq_busy_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R12
    strobe_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (busy && !conv_start));

    // R12
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> $stable(conv_chan));

    // R3
    scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == 2'b01) |-> (cur_chan <= last_q));

    // R7
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .irq       (irq),
    .conv_start(conv_start),
    .conv_done (conv_done),
    .conv_chan (conv_chan),
    .cur_chan  (cur_chan),
    .mode_q    (mode_q),
    .last_q    (last_q)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/100ps
module adc_seq_ctrl_test;

    localparam int CH_W  = 4;
    localparam int RES_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_mode = '0;
    logic [CH_W-1:0]  cfg_chan = '0;
    logic [CH_W-1:0]  cfg_last = '0;
    logic             cfg_trig_en = 1'b0;
    logic             cfg_start = 1'b0;
    logic             tmr_uf = 1'b0;
    logic             busy;
    logic [CH_W-1:0]  cur_chan;
    logic             conv_start;
    logic [CH_W-1:0]  conv_chan;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_data = '0;
    logic             irq;
    logic [CH_W-1:0]  rd_chan = '0;
    logic [RES_W-1:0] rd_data;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.CH_W(CH_W), .RES_W(RES_W)) uut (.*);

    int checks = 0;
    int errors = 0;
    int n_conv = 0;
    int n_irq = 0;
    int ord [64];
    int lat = 0;
    int salt = 0;
    int cycles = 0;

    function automatic logic [RES_W-1:0] dat(int ch, int s);
        return RES_W'((ch * 37 + s) % 1024);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // converter core model and monitor, on the falling edge
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [CH_W-1:0] held = '0;
        logic prev_busy = 1'b0;
        logic prev_start = 1'b0;
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL R7 watchdog: actual %0d expected %0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
            conv_done = 1'b0;
            if (rst_n) begin
                if (pend) begin
                    chk(conv_chan == held, "R12", "conv_chan held", int'(conv_chan), int'(held));
                    if (cnt == 0) begin
                        conv_done = 1'b1;
                        conv_data = dat(int'(held), salt);
                        pend = 0;
                    end else cnt--;
                end
                if (conv_start) begin
                    chk(!prev_start, "R12", "strobe width", 2, 1);
                    chk(cur_chan == conv_chan, "R4", "cur_chan at strobe", int'(cur_chan), int'(conv_chan));
                    if (n_conv < 64) ord[n_conv] = int'(conv_chan);
                    n_conv++;
                    pend = 1;
                    cnt = lat;
                    held = conv_chan;
                end
                if (irq) begin
                    n_irq++;
                    chk(!busy && prev_busy, "R8", "irq with busy falling", int'(busy), 0);
                end
            end
            prev_busy = busy;
            prev_start = conv_start;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] m, int ch, int lst, logic trig, logic st);
        cfg_mode    = m;
        cfg_chan    = CH_W'(ch);
        cfg_last    = CH_W'(lst);
        cfg_trig_en = trig;
        cfg_start   = st;
        cfg_we      = 1'b1;
        tick();
        cfg_we    = 1'b0;
        cfg_start = 1'b0;
    endtask

    task automatic pulse_tmr();
        tmr_uf = 1'b1;
        tick();
        tmr_uf = 1'b0;
    endtask

    task automatic wait_irq(int max);
        for (int k = 0; k < max && n_irq == 0; k++) tick();
        repeat (4) tick();
    endtask

    task automatic clear_counts();
        n_conv = 0;
        n_irq  = 0;
    endtask

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] chan;
        logic [3:0] last;
        logic       tmr;
        logic [4:0] exp_n;
        logic [3:0] exp_first;
        logic [3:0] exp_fin;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 4'd5,  4'd9,  1'b0, 5'd1,  4'd5,  4'd5},  // R2 last ignored
        '{2'b00, 4'd15, 4'd0,  1'b1, 5'd1,  4'd15, 4'd15}, // R2 via timer
        '{2'b01, 4'd7,  4'd3,  1'b0, 5'd4,  4'd0,  4'd0},  // R3 seeded at 0
        '{2'b01, 4'd0,  4'd0,  1'b1, 5'd1,  4'd0,  4'd0},  // R11
        '{2'b01, 4'd3,  4'd15, 1'b0, 5'd16, 4'd0,  4'd0},  // R3 full range
        '{2'b10, 4'd4,  4'd2,  1'b0, 5'd0,  4'd0,  4'd4},  // R13
        '{2'b00, 4'd0,  4'd15, 1'b0, 5'd1,  4'd0,  4'd0}   // R2 channel 0
    };

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        tick();
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(irq == 1'b0, "R1", "irq", int'(irq), 0);
        chk(conv_start == 1'b0, "R1", "conv_start", int'(conv_start), 0);
        chk(cur_chan == '0, "R1", "cur_chan", int'(cur_chan), 0);
        for (int c = 0; c < 16; c += 15) begin
            rd_chan = CH_W'(c);
            #1;
            chk(rd_data == '0, "R1", "result reg", int'(rd_data), 0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            string rq;
            int n;
            rq = (t.mode == 2'b00) ? "R2" : (t.mode == 2'b01) ? ((t.last == 0) ? "R11" : "R3") : "R13";
            n = int'(t.exp_n);
            salt = v * 53 + 11;
            lat = v % 3;
            clear_counts();
            if (t.tmr) begin
                wr(t.mode, int'(t.chan), int'(t.last), 1'b1, 1'b0);
                pulse_tmr();
            end else begin
                wr(t.mode, int'(t.chan), int'(t.last), 1'b0, 1'b1);
            end
            chk(busy == (n != 0), "R7", "busy after start", int'(busy), int'(n != 0));
            wait_irq(400);
            chk(n_conv == n, rq, "conversion count", n_conv, n);
            for (int i = 0; i < n; i++)
                chk(ord[i] == int'(t.exp_first) + i, rq, "channel order", ord[i], int'(t.exp_first) + i);
            chk(n_irq == int'(n != 0), "R8", "irq count", n_irq, int'(n != 0));
            chk(busy == 1'b0, "R7", "busy cleared", int'(busy), 0);
            chk(int'(cur_chan) == int'(t.exp_fin), "R4", "channel field after", int'(cur_chan), int'(t.exp_fin));
            for (int i = 0; i < n; i++) begin
                rd_chan = CH_W'(int'(t.exp_first) + i);
                #1;
                chk(rd_data == dat(int'(t.exp_first) + i, salt), "R9", "result",
                    int'(rd_data), int'(dat(int'(t.exp_first) + i, salt)));
            end
        end

        // R5: software start with trigger enable set is ignored
        salt = 200; lat = 1;
        clear_counts();
        wr(2'b00, 2, 0, 1'b1, 1'b1);
        repeat (20) tick();
        chk(n_conv == 0, "R5", "start with trig set", n_conv, 0);
        chk(busy == 1'b0, "R5", "busy stays low", int'(busy), 0);
        // R6: timer starts it
        pulse_tmr();
        wait_irq(100);
        chk(n_conv == 1 && ord[0] == 2, "R6", "timer start channel", ord[0], 2);

        // R6: timer ignored with trigger enable clear
        clear_counts();
        wr(2'b00, 3, 0, 1'b0, 1'b0);
        pulse_tmr();
        repeat (20) tick();
        chk(n_conv == 0, "R6", "timer with trig clear", n_conv, 0);

        // R10: write and timer while busy ignored
        salt = 300; lat = 2;
        clear_counts();
        wr(2'b01, 0, 5, 1'b1, 1'b0);
        pulse_tmr();
        repeat (2) tick();
        wr(2'b00, 9, 1, 1'b0, 1'b1);
        pulse_tmr();
        wait_irq(200);
        chk(n_conv == 6, "R10", "scan length under writes", n_conv, 6);
        for (int i = 0; i < 6; i++)
            chk(ord[i] == i, "R10", "scan order under writes", ord[i], i);
        chk(n_irq == 1, "R10", "single irq", n_irq, 1);
        repeat (10) tick();
        chk(n_conv == 6, "R10", "no restart", n_conv, 6);
        clear_counts();
        pulse_tmr();
        wait_irq(200);
        chk(n_conv == 6, "R10", "stored config kept", n_conv, 6);
        chk(cur_chan == '0, "R4", "channel field after scan", int'(cur_chan), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule